// File: doc/BRIEF.md
# RTC Alarm Match Interrupt Unit

This unit watches the hours, minutes and seconds of a real-time clock. Each time the timekeeping logic finishes an update and pulses a one-cycle update-done strobe, it compares those three time bytes against three programmable alarm bytes. When every byte that takes part in the compare agrees with the time, an alarm flag is set. If the alarm enable input is high, an interrupt request is raised as well.

An alarm byte whose two most significant bits are both 1 is a wildcard and is left out of the compare. This lets one comparator fire once per day, hour, minute or second. Software writes the alarm bytes over a small register bus and reads a status register. Reading the status register returns the flag and a summary interrupt bit, then clears the flag. The whole unit runs on one clock, so it keeps working when only the backup-domain clock is running and can serve as a wake-up source.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset the alarm flag, the interrupt output, the read data and all three alarm bytes are 0.
- R2: A write to address 0, 1 or 2 loads the seconds, minutes or hours alarm byte. A read of the same address returns it on the read data one clock after the read strobe.
- R3: On a clock where update-done is high and every non-wildcard alarm byte equals its time byte, the alarm flag is 1 from the next clock on.
- R4: An alarm byte with bits 7 and 6 both 1 matches any time value. A byte with only one of those bits set is compared literally.
- R5: With no wildcard bytes the flag sets only when hours, minutes and seconds all match. With hours as a wildcard it needs minutes and seconds. With hours and minutes as wildcards it needs seconds only. With all three as wildcards it sets on every update.
- R6: A matching time presented while update-done is low does not set the flag.
- R7: The interrupt output is high exactly when the flag is set and the alarm enable was high on the previous clock. With enable low the flag still sets but the interrupt stays low.
- R8: A read of address 3 (status) returns bit 7 = flag AND enable, bit 5 = flag, and 0 in all other bits. The same read clears the flag, which drops the interrupt on the next clock.
- R9: When a status read and a matching update fall on the same clock, the read returns the old state and the flag ends up set.
- R10: A write to address 3 changes neither the flag nor the status contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, which may be the backup-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte |
| upd_done | input | 1 | One-cycle strobe at the end of a time update |
| alarm_en | input | 1 | Alarm interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 sec, 1 min, 2 hr, 3 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| alarm_flag | output | 1 | Alarm flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a status read and a matching update on the same clock edge, where the clear and the set compete. The bench first leaves the flag set with an earlier match. It then raises the read strobe and update-done on the same falling edge and checks two things: the read returns the old flag, and the flag is still set afterward. Wildcard handling is reached by reprogramming the alarm bytes between updates. Each wildcard level is tested with a time that differs only in the bytes being ignored, and with one that differs in a byte still being compared.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned ALM_FIELDS = 3;
  localparam int unsigned ALM_DW     = 8;
  localparam int unsigned ALM_AW     = 2;
  localparam int unsigned STAT_FLAG_BIT = 5;
  localparam int unsigned STAT_IRQ_BIT  = 7;

  typedef enum logic [1:0] {
    RA_SEC  = 2'd0,
    RA_MIN  = 2'd1,
    RA_HR   = 2'd2,
    RA_STAT = 2'd3
  } alm_addr_e;
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2,
  parameter int unsigned NF = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [NF*DW-1:0] alarm_vec
);
  for (genvar i = 0; i < NF; i++) begin : g_byte
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (wr && addr == AW'(i)) q <= wdata;
    end
    assign alarm_vec[i*DW +: DW] = q;
  end
endmodule

// File: rtl/alarm_field_match.sv
module alarm_field_match #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] alarm_b,
  input  logic [DW-1:0] time_b,
  output logic          hit
);
  logic wild;
  always_comb begin
    wild = (alarm_b[DW-1:DW-2] == 2'b11);
    hit  = wild || (alarm_b == time_b);
  end
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic upd_done,
  input  logic all_match,
  input  logic stat_clr,
  input  logic alarm_en,
  output logic flag_q,
  output logic irq_q
);
  logic set_ev, flag_d;
  always_comb begin
    set_ev = upd_done && all_match;
    flag_d = set_ev || (flag_q && !stat_clr);
  end
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d && alarm_en;
    end
  end
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_pkg::*;
#(
  parameter int unsigned DW = ALM_DW,
  parameter int unsigned AW = ALM_AW,
  parameter int unsigned NF = ALM_FIELDS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cur_sec,
  input  logic [DW-1:0] cur_min,
  input  logic [DW-1:0] cur_hr,
  input  logic          upd_done,
  input  logic          alarm_en,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          alarm_flag,
  output logic          irq
);
  localparam logic [AW-1:0] STAT_ADDR = AW'(NF);

  logic [NF*DW-1:0] alarm_vec;
  logic [NF*DW-1:0] time_vec;
  logic [NF-1:0]    hits;
  logic             all_match;
  logic             stat_rd;
  logic [DW-1:0]    stat_val;
  logic [DW-1:0]    rd_mux;

  assign time_vec = {cur_hr, cur_min, cur_sec};

  alarm_regfile #(.DW(DW), .AW(AW), .NF(NF)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .alarm_vec(alarm_vec)
  );

  for (genvar i = 0; i < NF; i++) begin : g_cmp
    alarm_field_match #(.DW(DW)) u_cmp (
      .alarm_b(alarm_vec[i*DW +: DW]),
      .time_b (time_vec[i*DW +: DW]),
      .hit    (hits[i])
    );
  end

  assign all_match = &hits;
  assign stat_rd   = reg_rd && (reg_addr == STAT_ADDR);

  alarm_flag_ctrl u_flag (
    .clk(clk), .rst(rst), .upd_done(upd_done), .all_match(all_match),
    .stat_clr(stat_rd), .alarm_en(alarm_en),
    .flag_q(alarm_flag), .irq_q(irq)
  );

  always_comb begin
    stat_val = '0;
    stat_val[STAT_FLAG_BIT] = alarm_flag;
    stat_val[STAT_IRQ_BIT]  = alarm_flag && alarm_en;
    rd_mux = '0;
    if (reg_addr == STAT_ADDR) rd_mux = stat_val;
    else begin
      for (int i = 0; i < NF; i++)
        if (reg_addr == AW'(i)) rd_mux = alarm_vec[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       upd_done,
  input logic       all_match,
  input logic       alarm_en,
  input logic       reg_rd,
  input logic [1:0] reg_addr,
  input logic       alarm_flag,
  input logic       irq
);
  // R3
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_done && all_match) |=> alarm_flag);
  // R6
  flag_needs_update_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_flag) |-> $past(upd_done));
  // R7
  irq_implies_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> alarm_flag);
  // R7
  irq_follows_enable_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(alarm_flag) && $past(alarm_en)) |-> irq);
  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 2'd3 && !(upd_done && all_match)) |=> !alarm_flag);
  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 2'd3 && upd_done && all_match) |=> alarm_flag);
endmodule

bind alarm_irq_unit alarm_irq_chk u_chk (
  .clk(clk), .rst(rst), .upd_done(upd_done), .all_match(all_match),
  .alarm_en(alarm_en), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .alarm_flag(alarm_flag), .irq(irq)
);

// File: tb/alarm_irq_unit_tb.sv
module alarm_irq_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hr = '0;
  logic       upd_done = 1'b0, alarm_en = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       alarm_flag, irq;
  int n_run = 0, n_fail = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  alarm_irq_unit u_dut (
    .clk(clk), .rst(rst), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
    .upd_done(upd_done), .alarm_en(alarm_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alarm_flag(alarm_flag), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic update(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    @(negedge clk); cur_hr = h; cur_min = m; cur_sec = s; upd_done = 1'b1;
    @(negedge clk); upd_done = 1'b0;
  endtask

  task automatic clear_flag();
    logic [7:0] d;
    rd_reg(2'd3, d);
  endtask

  task automatic set_alarm(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr_reg(2'd2, h); wr_reg(2'd1, m); wr_reg(2'd0, s);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 flag", {7'd0, alarm_flag}, 8'd0);
    check("R1 irq", {7'd0, irq}, 8'd0);
    check("R1 rdata", reg_rdata, 8'd0);
    rd_reg(2'd0, d); check("R1 sec alarm", d, 8'd0);
    rd_reg(2'd2, d); check("R1 hr alarm", d, 8'd0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    set_alarm(8'h23, 8'h45, 8'h17);
    rd_reg(2'd0, d); check("R2 sec", d, 8'h17);
    rd_reg(2'd1, d); check("R2 min", d, 8'h45);
    rd_reg(2'd2, d); check("R2 hr", d, 8'h23);
  endtask

  task automatic t_daily();
    set_alarm(8'h07, 8'h30, 8'h00);
    update(8'h07, 8'h30, 8'h01);
    check("R5 daily sec off", {7'd0, alarm_flag}, 8'd0);
    update(8'h08, 8'h30, 8'h00);
    check("R5 daily hr off", {7'd0, alarm_flag}, 8'd0);
    update(8'h07, 8'h30, 8'h00);
    check("R3 daily match", {7'd0, alarm_flag}, 8'd1);
    clear_flag();
  endtask

  task automatic t_no_strobe();
    @(negedge clk); cur_hr = 8'h07; cur_min = 8'h30; cur_sec = 8'h00;
    @(negedge clk); @(negedge clk);
    check("R6 no strobe", {7'd0, alarm_flag}, 8'd0);
  endtask

  task automatic t_wild();
    set_alarm(8'hC0, 8'h15, 8'h20);
    update(8'h11, 8'h15, 8'h20);
    check("R5 hourly", {7'd0, alarm_flag}, 8'd1);
    clear_flag();
    update(8'h11, 8'h16, 8'h20);
    check("R5 hourly min off", {7'd0, alarm_flag}, 8'd0);
    set_alarm(8'hFF, 8'hC3, 8'h20);
    update(8'h02, 8'h59, 8'h20);
    check("R5 minutely", {7'd0, alarm_flag}, 8'd1);
    clear_flag();
    update(8'h02, 8'h59, 8'h21);
    check("R5 minutely sec off", {7'd0, alarm_flag}, 8'd0);
    set_alarm(8'hC0, 8'hC0, 8'hC0);
    update(8'h05, 8'h06, 8'h07);
    check("R4 R5 every second", {7'd0, alarm_flag}, 8'd1);
    clear_flag();
    set_alarm(8'h80, 8'h40, 8'hC0);
    update(8'h12, 8'h40, 8'h33);
    check("R4 single top bit literal", {7'd0, alarm_flag}, 8'd0);
    update(8'h80, 8'h40, 8'h33);
    check("R4 literal compare hits", {7'd0, alarm_flag}, 8'd1);
    clear_flag();
  endtask

  task automatic t_irq();
    logic [7:0] d;
    set_alarm(8'hC0, 8'hC0, 8'hC0);
    alarm_en = 1'b0;
    update(8'h00, 8'h00, 8'h00);
    check("R7 disabled flag", {7'd0, alarm_flag}, 8'd1);
    check("R7 disabled irq", {7'd0, irq}, 8'd0);
    rd_reg(2'd3, d);
    check("R8 status no irq", d, 8'h20);
    check("R8 cleared", {7'd0, alarm_flag}, 8'd0);
    @(negedge clk); alarm_en = 1'b1;
    update(8'h00, 8'h00, 8'h01);
    check("R7 enabled irq", {7'd0, irq}, 8'd1);
    rd_reg(2'd3, d);
    check("R8 status irq", d, 8'hA0);
    check("R8 irq dropped", {7'd0, irq}, 8'd0);
    rd_reg(2'd3, d);
    check("R8 status empty", d, 8'h00);
  endtask

  task automatic t_race();
    logic [7:0] d;
    update(8'h01, 8'h02, 8'h03);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 2'd3;
    cur_sec = 8'h04; upd_done = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; upd_done = 1'b0; d = reg_rdata;
    check("R9 old status", d, 8'hA0);
    check("R9 flag kept", {7'd0, alarm_flag}, 8'd1);
    clear_flag();
  endtask

  task automatic t_stat_write();
    logic [7:0] d;
    update(8'h09, 8'h09, 8'h09);
    wr_reg(2'd3, 8'h00);
    check("R10 flag after write", {7'd0, alarm_flag}, 8'd1);
    rd_reg(2'd3, d);
    check("R10 status after write", d, 8'hA0);
    wr_reg(2'd3, 8'hFF);
    rd_reg(2'd3, d);
    check("R10 no set by write", d, 8'h00);
  endtask

  initial begin
    #(4 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_daily();
    t_no_strobe();
    t_wild();
    t_irq();
    t_race();
    t_stat_write();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule